// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds recently used virtual-to-physical page mappings next to a core's load, store and instruction fetch path. A lookup presents a virtual page number together with the access kind and the privilege level of the requester. In the same cycle the block answers with a hit, the physical page number, a permission fault flag and the current dirty state of the matching entry. When the page is not held, a miss strobe asks the external page table walker for the mapping.

The walker returns a mapping through the fill port. The fill is written at the next clock edge. If the page is already held, its entry is overwritten. Otherwise the new mapping takes the lowest free slot or, when every slot is in use, the lowest slot whose reference bit is clear.

Reference bits are set by hits and by fills, and they approximate recency. A store that hits a writable page marks that page dirty, so it can later be written back. A flush empties the whole buffer in a single cycle.

Top module: `xlat_cache`

## Requirements
- R1: While `lkValid` is high, `lkHit` is high in the same cycle exactly when a valid entry holds `lkVpn`, and `lkPpn` then carries that entry's physical page number. `lkPpn` is zero whenever `lkHit` is low.
- R2: `lkMiss` is high exactly when `lkValid` is high and no valid entry holds `lkVpn`. Both `lkHit` and `lkMiss` are low while `lkValid` is low.
- R3: A fill presented in a cycle is written at that cycle's clock edge. A lookup in the same cycle still sees the old contents, and a lookup in the following cycle sees the new mapping.
- R4: A fill whose virtual page number is already held overwrites that entry's physical page number and permissions. No second copy is created and no other entry is evicted.
- R5: A fill for a page that is not held goes to the lowest-index invalid entry. If there is none, it goes to the lowest-index entry whose reference bit is clear, and failing that to entry 0.
- R6: Each lookup hit sets the matching entry's reference bit, and each fill sets the written entry's reference bit. If that leaves every reference bit set, all of them are cleared except the one just set.
- R7: `lkKind` encodes 0 as load, 1 as store, 2 as fetch and 3 as load. `lkFault` is high on a hit when a user access (`lkUser`=1) meets a page without user permission, when a store meets a non-writable page, or when a fetch meets a non-executable page. `lkFault` is low on a miss.
- R8: `lkDirty` shows the dirty bit of the hit entry. A store hit without a fault sets that bit at the clock edge. A faulting store leaves it unchanged, and a fill clears it.
- R9: `flush` invalidates every entry at the next edge and clears all reference and dirty bits. A fill presented in the same cycle as a flush is discarded.
- R10: When a fill or a flush is presented in the same cycle as a lookup hit, the lookup updates neither reference nor dirty state.
- R11: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | VPN_W | Virtual page number to translate |
| lkKind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| lkUser | input | 1 | 1 for a user-mode access, 0 for supervisor |
| lkHit | output | 1 | Mapping found |
| lkMiss | output | 1 | Mapping absent; request to the page table walker |
| lkPpn | output | PPN_W | Physical page number of the hit, zero otherwise |
| lkFault | output | 1 | Access rights violated on a hit |
| lkDirty | output | 1 | Dirty state of the hit entry before this access |
| fillValid | input | 1 | Walker returns a mapping |
| fillVpn | input | VPN_W | Virtual page number of the mapping |
| fillPpn | input | PPN_W | Physical page number of the mapping |
| fillUserOk | input | 1 | Page may be accessed in user mode |
| fillWritable | input | 1 | Page may be stored to |
| fillExec | input | 1 | Page may be fetched from |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench runs against an 8-entry configuration. A sweep over all eight permission combinations, crossed with every access kind and both privilege levels, separates each of the three fault causes and shows that the reserved kind behaves as a load. Fills of up to eight distinct pages, followed by further fills, reveal which slot each eviction picks. From this the bench tells apart first-free, first-unreferenced and the clearing of saturated reference bits. A long pseudo-random mix of lookups, fills, refills of held pages and rare flushes, drawn from 16 pages so that hits and misses both occur often, is compared against an arithmetic model kept in the bench. This mix also exercises fills and flushes that coincide with lookups.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  typedef struct packed {
    logic user;
    logic write;
    logic exec;
  } perm_t;

  typedef struct packed {
    logic clrAll;
    logic wrEn;
    logic touchEn;
    logic dirtyEn;
  } strobe_t;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                lkValid,
  input  logic [1:0]          lkKind,
  input  logic                lkFault,
  input  logic                fillValid,
  input  logic                flush,
  input  logic [ENTRIES-1:0]  matchVec,
  input  logic [ENTRIES-1:0]  fillMatchVec,
  input  logic [ENTRIES-1:0]  validVec,
  input  logic [ENTRIES-1:0]  refVec,
  output xlat_pkg::strobe_t   strb,
  output logic [IDX_W-1:0]    wrIdx,
  output logic [IDX_W-1:0]    touchIdx
);
  import xlat_pkg::*;

  function automatic logic [IDX_W-1:0] lowestSet(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic anyHit, dupAny, freeAny, coldAny;
  logic [IDX_W-1:0] dupIdx, freeIdx, coldIdx;

  always_comb begin
    anyHit   = |matchVec;
    touchIdx = lowestSet(matchVec);
    dupAny   = |fillMatchVec;
    dupIdx   = lowestSet(fillMatchVec);
    freeAny  = |(~validVec);
    freeIdx  = lowestSet(~validVec);
    coldAny  = |(~refVec);
    coldIdx  = lowestSet(~refVec);
    if (dupAny)       wrIdx = dupIdx;
    else if (freeAny) wrIdx = freeIdx;
    else if (coldAny) wrIdx = coldIdx;
    else              wrIdx = '0;
  end

  // flush beats fill, fill beats the lookup side effects
  always_comb begin
    strb.clrAll  = flush;
    strb.wrEn    = fillValid && !flush;
    strb.touchEn = lkValid && anyHit && !flush && !fillValid;
    strb.dirtyEn = strb.touchEn && (lkKind == ACC_STORE) && !lkFault;
  end

endmodule

// File: rtl/xlat_dp.sv
module xlat_dp #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  xlat_pkg::strobe_t   strb,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [IDX_W-1:0]    touchIdx,
  input  logic                lkValid,
  input  logic [VPN_W-1:0]    lkVpn,
  input  logic [1:0]          lkKind,
  input  logic                lkUser,
  input  logic [VPN_W-1:0]    fillVpn,
  input  logic [PPN_W-1:0]    fillPpn,
  input  xlat_pkg::perm_t     fillPerm,
  output logic [ENTRIES-1:0]  matchVec,
  output logic [ENTRIES-1:0]  fillMatchVec,
  output logic [ENTRIES-1:0]  validVec,
  output logic [ENTRIES-1:0]  refVec,
  output logic                lkHit,
  output logic                lkMiss,
  output logic [PPN_W-1:0]    lkPpn,
  output logic                lkFault,
  output logic                lkDirty
);
  import xlat_pkg::*;

  logic [ENTRIES-1:0]             dirtyVec;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppnAll;
  logic [ENTRIES-1:0][2:0]        permAll;
  logic [ENTRIES-1:0]             refQ, refSet, refNext;
  logic [IDX_W-1:0]               refPick;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic             validQ, dirtyQ;
    logic [VPN_W-1:0] vpnQ;
    logic [PPN_W-1:0] ppnQ;
    perm_t            permQ;
    logic             wrHere, touchHere;

    assign wrHere    = strb.wrEn && (wrIdx == IDX_W'(e));
    assign touchHere = strb.dirtyEn && (touchIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        dirtyQ <= 1'b0;
      end else if (strb.clrAll) begin
        validQ <= 1'b0;
        dirtyQ <= 1'b0;
      end else if (wrHere) begin
        validQ <= 1'b1;
        dirtyQ <= 1'b0;
      end else if (touchHere) begin
        dirtyQ <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        vpnQ  <= fillVpn;
        ppnQ  <= fillPpn;
        permQ <= fillPerm;
      end
    end

    assign matchVec[e]     = validQ && (vpnQ == lkVpn);
    assign fillMatchVec[e] = validQ && (vpnQ == fillVpn);
    assign validVec[e]     = validQ;
    assign dirtyVec[e]     = dirtyQ;
    assign ppnAll[e]       = ppnQ;
    assign permAll[e]      = permQ;
  end

  // one-hot selection of the hit entry's payload
  logic [PPN_W-1:0] ppnMux;
  perm_t            permMux;
  logic             dirtyMux, anyHit;

  always_comb begin
    ppnMux   = '0;
    permMux  = '0;
    dirtyMux = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        ppnMux   = ppnMux | ppnAll[i];
        permMux  = permMux | perm_t'(permAll[i]);
        dirtyMux = dirtyMux | dirtyVec[i];
      end
    end
    anyHit  = |matchVec;
    lkHit   = lkValid && anyHit;
    lkMiss  = lkValid && !anyHit;
    lkPpn   = lkHit ? ppnMux : '0;
    lkDirty = lkHit && dirtyMux;
    lkFault = lkHit && ((lkUser && !permMux.user) ||
                        ((lkKind == ACC_STORE) && !permMux.write) ||
                        ((lkKind == ACC_FETCH) && !permMux.exec));
  end

  // reference bits: set on touch, collapse to one when saturated
  always_comb begin
    refSet  = refQ;
    refPick = strb.wrEn ? wrIdx : touchIdx;
    if (strb.wrEn || strb.touchEn) refSet[refPick] = 1'b1;
    refNext = refSet;
    if (&refSet) begin
      refNext = '0;
      refNext[refPick] = 1'b1;
    end
    if (strb.clrAll) refNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refQ <= '0;
    else       refQ <= refNext;
  end

  assign refVec = refQ;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic [1:0]       lkKind,
  input  logic             lkUser,
  output logic             lkHit,
  output logic             lkMiss,
  output logic [PPN_W-1:0] lkPpn,
  output logic             lkFault,
  output logic             lkDirty,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             fillUserOk,
  input  logic             fillWritable,
  input  logic             fillExec,
  input  logic             flush
);
  import xlat_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  strobe_t            strb;
  logic [IDX_W-1:0]   wrIdx, touchIdx;
  logic [ENTRIES-1:0] matchVec, fillMatchVec, validVec, refVec;
  perm_t              fillPerm;

  assign fillPerm = '{user: fillUserOk, write: fillWritable, exec: fillExec};

  xlat_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .lkValid(lkValid), .lkKind(lkKind), .lkFault(lkFault),
    .fillValid(fillValid), .flush(flush),
    .matchVec(matchVec), .fillMatchVec(fillMatchVec),
    .validVec(validVec), .refVec(refVec),
    .strb(strb), .wrIdx(wrIdx), .touchIdx(touchIdx)
  );

  xlat_dp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .touchIdx(touchIdx),
    .lkValid(lkValid), .lkVpn(lkVpn), .lkKind(lkKind), .lkUser(lkUser),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillPerm(fillPerm),
    .matchVec(matchVec), .fillMatchVec(fillMatchVec),
    .validVec(validVec), .refVec(refVec),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPpn(lkPpn),
    .lkFault(lkFault), .lkDirty(lkDirty)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             lkValid,
  input logic [VPN_W-1:0] lkVpn,
  input logic [1:0]       lkKind,
  input logic             lkHit,
  input logic             lkMiss,
  input logic [PPN_W-1:0] lkPpn,
  input logic             lkFault,
  input logic             lkDirty,
  input logic             fillValid,
  input logic [VPN_W-1:0] fillVpn,
  input logic             flush
);

  a_r2_hit_miss_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(lkHit && lkMiss));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!lkHit && !lkMiss));

  a_r1_ppn_zero_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPpn == '0));

  a_r7_fault_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    lkFault |-> lkHit);

  a_r8_dirty_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    lkDirty |-> lkHit);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !lkHit);

  a_r3_fill_visible: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fillValid && !flush) && lkValid && (lkVpn == $past(fillVpn))) |-> lkHit);

  a_r8_store_marks_dirty: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lkHit && (lkKind == 2'd1) && !lkFault && !fillValid && !flush) &&
     lkValid && (lkVpn == $past(lkVpn))) |-> (lkHit && lkDirty));

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkKind(lkKind),
  .lkHit(lkHit), .lkMiss(lkMiss), .lkPpn(lkPpn), .lkFault(lkFault),
  .lkDirty(lkDirty), .fillValid(fillValid), .fillVpn(fillVpn), .flush(flush)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  localparam int N  = 8;
  localparam int VW = 8;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 1'b0, lkUser = 1'b0;
  logic [VW-1:0] lkVpn = '0;
  logic [1:0] lkKind = '0;
  logic lkHit, lkMiss, lkFault, lkDirty;
  logic [PW-1:0] lkPpn;
  logic fillValid = 1'b0, fillUserOk = 1'b0, fillWritable = 1'b0, fillExec = 1'b0;
  logic [VW-1:0] fillVpn = '0;
  logic [PW-1:0] fillPpn = '0;
  logic flush = 1'b0;

  always #2.5 clk = ~clk;

  xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkKind(lkKind),
    .lkUser(lkUser), .lkHit(lkHit), .lkMiss(lkMiss), .lkPpn(lkPpn),
    .lkFault(lkFault), .lkDirty(lkDirty), .fillValid(fillValid),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillUserOk(fillUserOk),
    .fillWritable(fillWritable), .fillExec(fillExec), .flush(flush)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int cyc = 0;

  // bench model of the buffer contents
  bit          mVal[N], mRef[N], mDirty[N], mU[N], mW[N], mX[N];
  logic [VW-1:0] mVpn[N];
  logic [PW-1:0] mPpn[N];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic int findMatch(input logic [VW-1:0] v);
    for (int i = 0; i < N; i++) if (mVal[i] && mVpn[i] == v) return i;
    return -1;
  endfunction

  task automatic touchRef(input int idx);
    bit all;
    mRef[idx] = 1'b1;
    all = 1'b1;
    for (int i = 0; i < N; i++) all &= mRef[i];
    if (all) begin
      for (int i = 0; i < N; i++) mRef[i] = 1'b0;
      mRef[idx] = 1'b1;
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit doLk, input logic [VW-1:0] vpn,
                      input logic [1:0] kind, input bit user, input bit doFill,
                      input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                      input bit fu, input bit fw, input bit fx, input bit doFl);
    int h, idx;
    bit eHit, eFault, eDirty;
    logic [PW-1:0] ePpn;
    lkValid = doLk; lkVpn = vpn; lkKind = kind; lkUser = user;
    fillValid = doFill; fillVpn = fv; fillPpn = fp;
    fillUserOk = fu; fillWritable = fw; fillExec = fx; flush = doFl;
    #1;
    h = findMatch(vpn);
    eHit = doLk && (h >= 0);
    ePpn = eHit ? mPpn[h] : '0;
    eFault = eHit && ((user && !mU[h]) || (kind == 2'd1 && !mW[h]) ||
                      (kind == 2'd2 && !mX[h]));
    eDirty = eHit && mDirty[h];
    chk(tag, "R1 hit", 32'(lkHit), 32'(eHit));
    chk(tag, "R2 miss", 32'(lkMiss), 32'(doLk && !eHit));
    chk(tag, "R1 ppn", 32'(lkPpn), 32'(ePpn));
    chk(tag, "R7 fault", 32'(lkFault), 32'(eFault));
    chk(tag, "R8 dirty", 32'(lkDirty), 32'(eDirty));
    @(posedge clk);
    if (doFl) begin
      for (int i = 0; i < N; i++) begin mVal[i] = 0; mRef[i] = 0; mDirty[i] = 0; end
    end else if (doFill) begin
      idx = findMatch(fv);
      if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!mVal[i]) idx = i;
      if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!mRef[i]) idx = i;
      if (idx < 0) idx = 0;
      mVal[idx] = 1; mVpn[idx] = fv; mPpn[idx] = fp; mDirty[idx] = 0;
      mU[idx] = fu; mW[idx] = fw; mX[idx] = fx;
      touchRef(idx);
    end else if (eHit) begin
      touchRef(h);
      if (kind == 2'd1 && !eFault) mDirty[h] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic look(input string tag, input logic [VW-1:0] v,
                      input logic [1:0] k, input bit u);
    step(tag, 1, v, k, u, 0, '0, '0, 0, 0, 0, 0);
  endtask

  task automatic fill(input string tag, input logic [VW-1:0] v, input logic [PW-1:0] p,
                      input bit u, input bit w, input bit x);
    step(tag, 0, '0, 2'd0, 0, 1, v, p, u, w, x, 0);
  endtask

  task automatic doFlush(input string tag);
    step(tag, 0, '0, 2'd0, 0, 0, '0, '0, 0, 0, 0, 1);
  endtask

  initial begin
    logic [15:0] lf;
    logic [15:0] lg;
    for (int i = 0; i < N; i++) begin
      mVal[i] = 0; mRef[i] = 0; mDirty[i] = 0; mU[i] = 0; mW[i] = 0; mX[i] = 0;
      mVpn[i] = '0; mPpn[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: empty after reset
    for (int v = 0; v < 16; v++) look("R11", VW'(v), 2'd0, 0);

    // R3: same-cycle lookup sees old contents, next cycle sees new
    step("R3", 1, 8'h05, 2'd0, 0, 1, 8'h05, 8'hA5, 1, 1, 1, 0);
    look("R3", 8'h05, 2'd0, 0);

    // R4: refill of a held page overwrites in place
    fill("R4", 8'h05, 8'h3C, 1, 0, 1);
    look("R4", 8'h05, 2'd0, 0);
    look("R4", 8'h05, 2'd1, 0);

    // R7: every permission combination against every kind and level
    doFlush("R7");
    for (int p = 0; p < 8; p++)
      fill("R7", VW'(8'h40 + p), PW'(8'h80 + p), p[0], p[1], p[2]);
    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 4; k++)
        for (int u = 0; u < 2; u++) look("R7", VW'(8'h40 + p), 2'(k), u[0]);

    // R8: first store marks dirty, faulting store does not, refill clears
    doFlush("R8");
    fill("R8", 8'h09, 8'h19, 1, 1, 0);
    look("R8", 8'h09, 2'd1, 0);
    look("R8", 8'h09, 2'd0, 0);
    fill("R8", 8'h0A, 8'h1A, 1, 0, 0);
    look("R8", 8'h0A, 2'd1, 0);
    look("R8", 8'h0A, 2'd0, 0);
    fill("R8", 8'h09, 8'h29, 1, 1, 0);
    look("R8", 8'h09, 2'd0, 0);

    // R5 and R6: replacement order
    doFlush("R5");
    for (int v = 0; v < 8; v++) fill("R5", VW'(8'h10 + v), PW'(8'h60 + v), 1, 1, 1);
    fill("R5", 8'h20, 8'h70, 1, 1, 1);
    for (int v = 0; v < 8; v++) look("R5", VW'(8'h10 + v), 2'd0, 0);
    look("R6", 8'h20, 2'd0, 0);
    fill("R6", 8'h21, 8'h71, 1, 1, 1);
    fill("R6", 8'h22, 8'h72, 1, 1, 1);
    for (int v = 0; v < 8; v++) look("R6", VW'(8'h10 + v), 2'd0, 0);
    for (int v = 0; v < 3; v++) look("R6", VW'(8'h20 + v), 2'd0, 0);

    // R9: flush wins over a simultaneous fill
    step("R9", 1, 8'h20, 2'd0, 0, 1, 8'h30, 8'h77, 1, 1, 1, 1);
    look("R9", 8'h30, 2'd0, 0);
    look("R9", 8'h20, 2'd0, 0);

    // R10: a fill in the lookup cycle suppresses the dirty update
    fill("R10", 8'h31, 8'h51, 1, 1, 1);
    step("R10", 1, 8'h31, 2'd1, 0, 1, 8'h32, 8'h52, 1, 1, 1, 0);
    look("R10", 8'h31, 2'd0, 0);
    step("R10", 1, 8'h31, 2'd1, 0, 0, '0, '0, 0, 0, 0, 1);
    look("R10", 8'h31, 2'd0, 0);

    // mixed pseudo-random traffic against the model
    lf = 16'hACE1;
    lg = 16'h1D2B;
    for (int n = 0; n < 4000; n++) begin
      bit rFl, rFill, rLk;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lg = {lg[14:0], lg[15] ^ lg[13] ^ lg[12] ^ lg[10]};
      rFl   = (lf[5:0] == 6'd0);
      rFill = (lf[7:6] == 2'd0);
      rLk   = lf[8] | !rFill;
      step("R6 mix", rLk, VW'(lf[12:9]), lf[14:13], lf[15], rFill,
           VW'(lg[3:0]), PW'(lg[11:4]), lg[12], lg[13], lg[14], rFl);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule